// File: doc/BRIEF.md
# Two-Wire Serial Sector-Programmed Memory Slave

This block is the slave end of a two-wire serial bus (I2C-style) in front of a 4K x 8 byte memory held in an on-chip register array. SCL and SDA are oversampled through a synchronizer on the system clock. SDA is driven through an open-drain enable: while `sda_oe_o` is high the pad pulls the line low. A control byte that follows a start condition picks one of up to eight devices by comparing against a 3-bit strap. Two address bytes then set the word address, and the master follows them with data bytes to write or with a repeated start to read.

Write data is gathered into a 32-byte sector buffer. When a stop closes a write, the block asks an external permission input about the sector being written. If permission is given, it enters a self-timed program period of a fixed number of clocks and copies the buffered bytes into the array at the end of that period. While this period lasts, the block answers nothing on the bus, so the master learns that programming has finished by polling until the control byte is acknowledged again. Reads can be random (a dummy write that sets the address, then a repeated start), current-address, or sequential.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset `sda_oe_o` and `busy_o` are low.
- R2: The control byte is `1010 s2 s1 s0 rw`, MSB first. It is acknowledged only when bits 3..1 equal `sel_i`, bits 7..4 equal 1010 and the block is not busy. Otherwise the block leaves SDA released until the next start.
- R3: After a write control byte, two address bytes follow and each is acknowledged. The low 4 bits of the first byte are address bits 11..8 and its upper 4 bits are ignored. The second byte is address bits 7..0.
- R4: Each data byte is acknowledged and stored in the sector buffer at the current offset, which is address bits 4..0. The offset wraps within the 32-byte sector and never carries into bit 5.
- R5: A stop after at least one data byte, with `wr_allow_i` high for the sector on `prog_sect_o`, raises `busy_o` for exactly PROG_CYC clocks. Only the bytes that were written are updated in the array, and they become visible when `busy_o` falls.
- R6: While `busy_o` is high the block never drives SDA, so a control byte goes unacknowledged.
- R7: If `wr_allow_i` is low at that stop, no program period starts and the array keeps its contents.
- R8: A random read returns the byte stored at the address given in the dummy write.
- R9: A current-address read returns the byte that follows the last byte accessed.
- R10: In a read, each master acknowledge makes the block send the byte at the next address. The address wraps from 0xFFF to 0x000.
- R11: A master no-acknowledge ends the read, and the block leaves SDA released.
- R12: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| sda_oe_o | output | 1 | Pull SDA low when high |
| sel_i | input | 3 | Device select strap |
| wr_allow_i | input | 1 | Program permission for the sector on prog_sect_o |
| prog_sect_o | output | ADDR_W-5 | Sector of the write in progress |
| busy_o | output | 1 | Program period active |

## Verification
A corrupted sector offset or address counter shows up at the next read-back: bytes land on the wrong word, or a current-address or sequential read returns the wrong neighbour. The slip appears on the first byte read after the fault. A wrong program timer shows up in the measured length of `busy_o` and in the point at which polling is acknowledged again, within a single program period. A wrong acknowledge decision, such as a missed select mismatch or an acknowledge given while busy, is visible as an SDA low on the ninth clock of that very byte.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_ACK, ST_TX, ST_MACK
  } twi_st_e;
  localparam logic [3:0] CTRL_ID = 4'b1010;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_N:0] scl_p, sda_p;
  logic scl_s, scl_d, sda_s, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_N-1:0], scl_i};
      sda_p <= {sda_p[SYNC_N-1:0], sda_i};
    end
  end

  assign scl_s = scl_p[SYNC_N-1];
  assign scl_d = scl_p[SYNC_N];
  assign sda_s = sda_p[SYNC_N-1];
  assign sda_d = sda_p[SYNC_N];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_sector_buf.sv
module twi_sector_buf #(
  parameter int SECT_W = 5,
  localparam int NB = 1 << SECT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  wr_i,
  input  logic [SECT_W-1:0]     idx_i,
  input  logic [7:0]            data_i,
  output logic [NB-1:0][7:0]    data_o,
  output logic [NB-1:0]         mask_o
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[i] <= '0;
        mask_o[i] <= 1'b0;
      end else if (clr_i) begin
        mask_o[i] <= 1'b0;
      end else if (wr_i && idx_i == SECT_W'(i)) begin
        data_o[i] <= data_i;
        mask_o[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int ADDR_W = 12,
  parameter int SECT_W = 5,
  localparam int NB    = 1 << SECT_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       we_i,
  input  logic [ADDR_W-SECT_W-1:0]   sect_i,
  input  logic [NB-1:0][7:0]         data_i,
  input  logic [NB-1:0]              mask_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [7:0]                 rd_data_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int i = 0; i < NB; i++) begin
        if (mask_i[i]) mem[{sect_i, SECT_W'(i)}] <= data_i[i];
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int SECT_W   = 5,
  parameter int PROG_CYC = 1000,
  parameter int SYNC_N   = 2,
  localparam int SECT_AW = ADDR_W - SECT_W,
  localparam int HI_W    = ADDR_W - 8,
  localparam int NB      = 1 << SECT_W,
  localparam int CW      = $clog2(PROG_CYC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [2:0]         sel_i,
  input  logic               wr_allow_i,
  output logic [SECT_AW-1:0] prog_sect_o,
  output logic               busy_o
);
  logic sda_s, scl_rise, scl_fall, start_c, stop_c;

  twi_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  twi_st_e            st, after_st;
  logic [7:0]         sreg, tx_sh;
  logic [3:0]         bit_cnt;
  logic               m_ack, wr_pend, oe_q, busy_q;
  logic [HI_W-1:0]    addr_hi;
  logic [ADDR_W-1:0]  addr_cnt, new_addr;
  logic [SECT_AW-1:0] sect_q;
  logic [SECT_W-1:0]  idx_q;
  logic [CW-1:0]      prg_cnt;
  logic               byte_done, dev_hit, buf_clr, buf_wr, commit_go, mem_we;
  logic [NB-1:0][7:0] buf_data;
  logic [NB-1:0]      buf_mask;
  logic [7:0]         rd_data;

  always_comb begin
    byte_done = scl_fall && bit_cnt == 4'd8;
    dev_hit   = sreg[7:4] == CTRL_ID && sreg[3:1] == sel_i && !busy_q;
    new_addr  = {addr_hi, sreg};
    buf_clr   = st == ST_ALO && byte_done && !start_c && !stop_c;
    buf_wr    = st == ST_WR && byte_done && !start_c && !stop_c;
    commit_go = stop_c && st == ST_WR && wr_pend && !busy_q;
    mem_we    = busy_q && prg_cnt == '0;
  end

  twi_sector_buf #(.SECT_W(SECT_W)) u_buf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .wr_i(buf_wr), .idx_i(idx_q),
    .data_i(sreg), .data_o(buf_data), .mask_o(buf_mask)
  );

  twi_mem_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_mem (
    .clk_i, .we_i(mem_we), .sect_i(sect_q), .data_i(buf_data),
    .mask_i(buf_mask), .rd_addr_i(addr_cnt), .rd_data_o(rd_data)
  );

  // bus protocol engine
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      after_st <= ST_IDLE;
      sreg     <= '0;
      tx_sh    <= '0;
      bit_cnt  <= '0;
      m_ack    <= 1'b0;
      wr_pend  <= 1'b0;
      oe_q     <= 1'b0;
      addr_hi  <= '0;
      addr_cnt <= '0;
      sect_q   <= '0;
      idx_q    <= '0;
    end else if (start_c) begin
      st      <= ST_DEV;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (stop_c) begin
      st   <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st)
        ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            sreg    <= {sreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            st      <= ST_ACK;
            oe_q    <= 1'b1;
            unique case (st)
              ST_DEV: begin
                if (dev_hit) after_st <= sreg[0] ? ST_TX : ST_AHI;
                else begin
                  st   <= ST_IDLE;
                  oe_q <= 1'b0;
                end
              end
              ST_AHI: begin
                addr_hi  <= sreg[HI_W-1:0];
                after_st <= ST_ALO;
              end
              ST_ALO: begin
                addr_cnt <= new_addr;
                sect_q   <= new_addr[ADDR_W-1:SECT_W];
                idx_q    <= new_addr[SECT_W-1:0];
                wr_pend  <= 1'b0;
                after_st <= ST_WR;
              end
              default: begin
                idx_q    <= idx_q + SECT_W'(1);
                addr_cnt <= {sect_q, idx_q + SECT_W'(1)};
                wr_pend  <= 1'b1;
                after_st <= ST_WR;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (after_st == ST_TX) begin
              tx_sh    <= rd_data;
              oe_q     <= ~rd_data[7];
              addr_cnt <= addr_cnt + ADDR_W'(1);
              st       <= ST_TX;
            end else begin
              oe_q <= 1'b0;
              st   <= after_st;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              oe_q    <= 1'b0;
              bit_cnt <= '0;
              st      <= ST_MACK;
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              oe_q    <= ~tx_sh[6];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) m_ack <= ~sda_s;
          else if (scl_fall) begin
            if (m_ack) begin
              tx_sh    <= rd_data;
              oe_q     <= ~rd_data[7];
              addr_cnt <= addr_cnt + ADDR_W'(1);
              bit_cnt  <= '0;
              st       <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // self-timed program period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      prg_cnt <= '0;
    end else if (commit_go && wr_allow_i) begin
      busy_q  <= 1'b1;
      prg_cnt <= CW'(PROG_CYC - 1);
    end else if (busy_q) begin
      if (prg_cnt == '0) busy_q <= 1'b0;
      else prg_cnt <= prg_cnt - CW'(1);
    end
  end

  assign sda_oe_o    = oe_q;
  assign busy_o      = busy_q;
  assign prog_sect_o = sect_q;
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
  import twi_mem_pkg::*;
#(
  parameter int PROG_CYC = 1000
) (
  input logic    clk_i,
  input logic    rst_ni,
  input logic    scl_i,
  input logic    sda_oe_o,
  input logic    busy_o,
  input logic    wr_allow_i,
  input twi_st_e st
);
  int busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  a_r12_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(sda_oe_o) |-> !scl_i);

  a_r6_quiet_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);

  a_r5_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_len == PROG_CYC);

  a_r7_allow_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_allow_i));

  a_r11_idle_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_IDLE |-> !sda_oe_o);
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .busy_o(busy_o), .wr_allow_i(wr_allow_i), .st(st)
);

// File: tb/sim_twi_mem_slave.sv
module sim_twi_mem_slave;
  localparam int Q = 10;
  localparam logic [7:0] CW_B = 8'hAA;  // 1010_101_0
  localparam logic [7:0] CR_B = 8'hAB;
  localparam logic [19:0] VEC [6] = '{20'h0005A, 20'h123C3, 20'h7FF01,
                                      20'hFFFE7, 20'h80080, 20'h9E0AB};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, lock = 1'b0;
  logic sda_oe, busy;
  logic [6:0] psect;
  wire  sda_line = !(m_low | sda_oe);
  wire  allow = !(lock && psect == 7'd9);
  int   n_run = 0, n_fail = 0, cur_len = 0, last_len = 0;

  always #2 clk = ~clk;

  twi_mem_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .sel_i(3'b101), .wr_allow_i(allow),
    .prog_sect_o(psect), .busy_o(busy)
  );

  always @(negedge clk) begin
    if (busy) cur_len++;
    else if (cur_len > 0) begin last_len = cur_len; cur_len = 0; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic send_bit(input logic b);
    m_low = !b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    m_low = 1'b0; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(r);
    ack = !r;
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) recv_bit(b[i]);
    send_bit(!ack_it);
  endtask

  task automatic addr_phase(input logic [3:0] pad, input logic [11:0] a);
    logic ack;
    bus_start();
    send_byte(CW_B, ack);           chk("R2 ctrl ack", ack, 1);
    send_byte({pad, a[11:8]}, ack); chk("R3 hi ack", ack, 1);
    send_byte(a[7:0], ack);         chk("R3 lo ack", ack, 1);
  endtask

  task automatic poll();
    logic ack;
    for (int i = 0; i < 40; i++) begin
      bus_start(); send_byte(CW_B, ack); bus_stop();
      if (ack) break;
    end
  endtask

  task automatic start_read(input logic [3:0] pad, input logic [11:0] a);
    logic ack;
    addr_phase(pad, a);
    bus_start();
    send_byte(CR_B, ack); chk("R8 read ctrl ack", ack, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk("R1 oe reset", sda_oe, 0);
    chk("R1 busy reset", busy, 0);
    rst_n = 1'b1;
    wq();

    // vector table: single-byte write, poll, random read
    for (int v = 0; v < 6; v++) begin
      addr_phase(4'h0, VEC[v][19:8]);
      send_byte(VEC[v][7:0], ack); chk("R4 data ack", ack, 1);
      bus_stop();
      poll();
      start_read(4'h0, VEC[v][19:8]);
      recv_byte(1'b0, d); bus_stop();
      chk("R8 random read", d, VEC[v][7:0]);
    end

    // R5/R6: sector write, busy, nack while busy
    addr_phase(4'h0, 12'h240);
    send_byte(8'h11, ack); send_byte(8'h22, ack);
    send_byte(8'h33, ack); send_byte(8'h44, ack);
    bus_stop();
    chk("R5 busy high", busy, 1);
    bus_start(); send_byte(CW_B, ack); bus_stop();
    chk("R6 nack busy", ack, 0);
    poll();
    chk("R5 busy length", last_len, 1000);

    // R10 sequential read, R11 release
    start_read(4'h0, 12'h240);
    recv_byte(1'b1, d); chk("R10 seq0", d, 8'h11);
    recv_byte(1'b1, d); chk("R10 seq1", d, 8'h22);
    recv_byte(1'b1, d); chk("R10 seq2", d, 8'h33);
    recv_byte(1'b0, d); chk("R10 seq3", d, 8'h44);
    chk("R11 released", sda_oe, 0);
    bus_stop();

    // R9 current address read
    start_read(4'h0, 12'h240); recv_byte(1'b0, d); bus_stop();
    bus_start(); send_byte(CR_B, ack); recv_byte(1'b0, d); bus_stop();
    chk("R9 current read", d, 8'h22);

    // R3 upper bits of high address byte ignored
    start_read(4'hF, 12'h243); recv_byte(1'b0, d); bus_stop();
    chk("R3 pad ignored", d, 8'h44);

    // R4 wrap within sector
    addr_phase(4'h0, 12'h25E);
    send_byte(8'hA1, ack); send_byte(8'hA2, ack); send_byte(8'hA3, ack);
    bus_stop(); poll();
    start_read(4'h0, 12'h240); recv_byte(1'b0, d); bus_stop();
    chk("R4 wrap to sector start", d, 8'hA3);
    start_read(4'h0, 12'h25F); recv_byte(1'b0, d); bus_stop();
    chk("R4 sector end", d, 8'hA2);
    start_read(4'h0, 12'h241); recv_byte(1'b0, d); bus_stop();
    chk("R4 untouched byte", d, 8'h22);

    // R10 wrap at top of memory
    start_read(4'h0, 12'hFFF);
    recv_byte(1'b1, d); chk("R10 top", d, 8'hE7);
    recv_byte(1'b0, d); chk("R10 wrap zero", d, 8'h5A);
    bus_stop();

    // R2 select mismatch and wrong id
    bus_start(); send_byte(8'hA0, ack); chk("R2 sel mismatch", ack, 0);
    send_byte(8'h00, ack); chk("R2 stays silent", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'hBA, ack); chk("R2 wrong id", ack, 0);
    bus_stop();

    // R7 write denied
    lock = 1'b1;
    addr_phase(4'h0, 12'h123);
    send_byte(8'h77, ack);
    bus_stop(); wq();
    chk("R7 no busy", busy, 0);
    start_read(4'h0, 12'h123); recv_byte(1'b0, d); bus_stop();
    chk("R7 contents kept", d, 8'hC3);
    lock = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule